// File: doc/BRIEF.md
# Ethernet Transmit Framer with Pause Hold-off

This block turns byte streams held in an external transmit FIFO into complete Ethernet frames on a byte-wide media interface. Each frame gets a leading preamble and start delimiter. When the frame is short it is padded with zeros, and a CRC-32 frame check sequence is appended. The FIFO is show-ahead: the current byte and its end-of-frame marker are visible while the FIFO is not empty, and a byte is consumed on each clock edge where the read strobe is high. The source must keep the FIFO supplied for the whole length of a frame once that frame has started.

A per-frame control can switch off FCS generation for frames that already carry a check sequence. Such frames leave the block exactly as supplied. When one of them is shorter than the minimum Ethernet size, a one-cycle status pulse marks it. A flow-control request from the receive side carries a quanta count. The frame in flight always completes, and after that no new frame may begin until the requested number of 64-byte-clock quanta have passed outside any frame. A fixed interframe gap separates every pair of frames, and an output flags that gap.

Top module: `eth_tx_framer`

## Requirements
- R1: While `tx_enable` is low and no frame is in progress, the block starts no frame and never asserts `fifo_rd`.
- R2: A frame starts only when `tx_enable`, `fifo_not_empty` and `fifo_avail` are all high and no pause hold-off is pending.
- R3: Every frame starts on the media interface with seven bytes of 0x55 and then one byte of 0xD5, with `tx_en_o` high on all of them.
- R4: The FIFO bytes follow the start delimiter in FIFO order up to and including the byte flagged by `fifo_last`. `tx_en_o` stays high without a break from the first preamble byte to the last byte of the frame.
- R5: With `fcs_disable` low at frame start, four FCS bytes follow the data. The FCS is CRC-32 (polynomial 0x04C11DB7, bit-reflected, preset to all ones, final value inverted) taken over data and pad, and it is sent least significant byte first.
- R6: With FCS generation on, a frame with fewer than 60 data bytes is padded with 0x00 bytes to exactly 60 before the FCS.
- R7: With `fcs_disable` high at frame start, the data bytes are sent exactly as supplied, with no pad and no FCS. `short_o` pulses for one cycle, together with the last byte, only when such a frame has fewer than 64 bytes in total after the delimiter.
- R8: A pause request that arrives during a frame does not shorten or interrupt that frame.
- R9: After a pause request with quanta Q > 0, no new frame starts until Q×64 clock cycles have passed in which no frame was in progress.
- R10: A pause request with quanta 0 cancels any remaining hold-off at once.
- R11: Between the last byte of one frame and the first byte of the next there are at least 12 cycles with `tx_en_o` low. `gap_o` is high for exactly 12 of those cycles after each frame.
- R12: After reset, `tx_en_o`, `short_o`, `gap_o` and `fifo_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_enable | input | 1 | Allows new frames to start |
| fcs_disable | input | 1 | Sampled at frame start; high sends data as supplied, with no pad and no FCS |
| pause_req | input | 1 | One-cycle flow-control request strobe |
| pause_quanta | input | QUANTA_W | Hold-off length in quanta; 0 cancels |
| fifo_not_empty | input | 1 | FIFO holds at least one byte |
| fifo_avail | input | 1 | FIFO reports a frame ready to send |
| fifo_data | input | 8 | Show-ahead FIFO byte |
| fifo_last | input | 1 | Current FIFO byte ends the frame |
| fifo_rd | output | 1 | Consumes the current FIFO byte at the clock edge |
| txd_o | output | 8 | Media interface byte |
| tx_en_o | output | 1 | Media interface byte valid |
| gap_o | output | 1 | High during the enforced interframe gap |
| short_o | output | 1 | Short frame pulse when FCS generation is off |

## Verification
On every cycle the assertions check several rules. Reads and frame starts follow the enable, available and hold-off conditions. Pad bytes come out as zeros. The delimiter follows the preamble. The gap flag never overlaps valid data. A pending hold-off keeps the block idle, and a zero-quanta request clears it. Only the bench scenarios can show whole-frame content: byte order, the value and byte order of the CRC, and exact pad length. They also cover the timing between frames: the measured idle gap, the length of the hold-off counted from the end of a frame, a cancelled hold-off, and the position of the short-frame pulse.

// File: rtl/eth_txf_pkg.sv
package eth_txf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_SFD,
      ST_DATA,
      ST_PAD,
      ST_FCS,
      ST_GAP
   } txf_state_e;

   localparam logic [7:0] PRE_BYTE = 8'h55;
   localparam logic [7:0] SFD_BYTE = 8'hD5;
   localparam int         FCS_LEN  = 4;

   // mirror bit order of a 32-bit word
   function automatic logic [31:0] reflect32(input logic [31:0] v);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) begin
         r[i] = v[31-i];
      end
      return r;
   endfunction

endpackage

// File: rtl/eth_txf_crc.sv
module eth_txf_crc #(
   parameter logic [31:0] POLY      = 32'h04C11DB7,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear,
   input  logic        advance,
   input  logic [7:0]  din,
   output logic [31:0] crc_o
);
   localparam logic [31:0] RPOLY = eth_txf_pkg::reflect32(POLY);

   logic [31:0] crc_q;
   logic [31:0] crc_nxt;

   generate
      if (LSB_FIRST) begin : g_reflected
         always_comb begin
            logic [31:0] c;
            logic        fb;
            c = crc_q;
            for (int i = 0; i < 8; i++) begin
               fb = c[0] ^ din[i];
               c  = {1'b0, c[31:1]};
               if (fb) c = c ^ RPOLY;
            end
            crc_nxt = c;
         end
      end else begin : g_direct
         always_comb begin
            logic [31:0] c;
            logic        fb;
            c = crc_q;
            for (int i = 0; i < 8; i++) begin
               fb = c[31] ^ din[7-i];
               c  = {c[30:0], 1'b0};
               if (fb) c = c ^ POLY;
            end
            crc_nxt = c;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       crc_q <= '1;
      else if (clear)   crc_q <= '1;
      else if (advance) crc_q <= crc_nxt;
   end

   assign crc_o = crc_q;

   // R5: a cleared register holds the all-ones preset on the next cycle
   assert_crc_preset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (crc_o == 32'hFFFF_FFFF))
      else $error("crc preset missing after clear");

endmodule

// File: rtl/eth_txf_pause.sv
module eth_txf_pause #(
   parameter int QUANTA_W      = 16,
   parameter int QUANTUM_BYTES = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req,
   input  logic [QUANTA_W-1:0] quanta,
   input  logic                in_frame,
   output logic                busy
);
   localparam int SH    = $clog2(QUANTUM_BYTES);
   localparam bit POW2  = ((1 << SH) == QUANTUM_BYTES);
   localparam int CNT_W = QUANTA_W + SH + (POW2 ? 0 : 1);

   generate
      if (QUANTUM_BYTES < 2) begin : g_bad_quantum
         $error("QUANTUM_BYTES must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] cnt_q;

   generate
      if (POW2) begin : g_shift
         assign load_val = {quanta, {SH{1'b0}}};
      end else begin : g_mult
         assign load_val = CNT_W'(quanta) * CNT_W'(QUANTUM_BYTES);
      end
   endgenerate

   // counts down only outside of a frame, so a frame in flight is never cut
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt_q <= '0;
      else if (req)                        cnt_q <= load_val;
      else if (!in_frame && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);

   // R10: zero quanta clears the hold-off
   assert_cancel_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req && quanta == '0) |=> !busy)
      else $error("zero quanta did not cancel hold-off");

   // R9: a nonzero request always arms the hold-off
   assert_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req && quanta != '0) |=> busy)
      else $error("pause request did not arm hold-off");

   // R8: remaining hold-off is frozen while a frame is on the wire
   assert_freeze_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame && !req) |=> $stable(cnt_q))
      else $error("hold-off counted during a frame");

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer #(
   parameter int          PREAMBLE_LEN  = 7,
   parameter int          IFG_BYTES     = 12,
   parameter int          MIN_FRAME     = 64,
   parameter int          LEN_W         = 16,
   parameter int          QUANTA_W      = 16,
   parameter int          QUANTUM_BYTES = 64,
   parameter logic [31:0] CRC_POLY      = 32'h04C11DB7,
   parameter bit          CRC_LSB_FIRST = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tx_enable,
   input  logic                fcs_disable,
   input  logic                pause_req,
   input  logic [QUANTA_W-1:0] pause_quanta,
   input  logic                fifo_not_empty,
   input  logic                fifo_avail,
   input  logic [7:0]          fifo_data,
   input  logic                fifo_last,
   output logic                fifo_rd,
   output logic [7:0]          txd_o,
   output logic                tx_en_o,
   output logic                gap_o,
   output logic                short_o
);
   import eth_txf_pkg::*;

   localparam int PAD_TARGET = MIN_FRAME - FCS_LEN;
   localparam int STEP_MAX   = (IFG_BYTES > PREAMBLE_LEN) ?
                               ((IFG_BYTES > FCS_LEN) ? IFG_BYTES : FCS_LEN) :
                               ((PREAMBLE_LEN > FCS_LEN) ? PREAMBLE_LEN : FCS_LEN);
   localparam int STEP_W     = $clog2(STEP_MAX);

   generate
      if (PREAMBLE_LEN < 1) begin : g_bad_pre
         $error("PREAMBLE_LEN must be at least 1");
      end
      if (IFG_BYTES < 1) begin : g_bad_ifg
         $error("IFG_BYTES must be at least 1");
      end
      if (MIN_FRAME <= FCS_LEN || MIN_FRAME >= (1 << LEN_W)) begin : g_bad_min
         $error("MIN_FRAME out of range for LEN_W");
      end
   endgenerate

   // ---------------- state ----------------
   txf_state_e        state_q, state_d;
   logic [STEP_W-1:0] step_q, step_d;
   logic [LEN_W-1:0]  len_q, len_d;
   logic              nofcs_q, nofcs_d;

   logic [7:0]        byte_d;
   logic              en_d;
   logic              short_d;
   logic              pause_busy;
   logic              in_frame;
   logic              crc_clear;
   logic              crc_adv;
   logic [31:0]       crc_val;
   logic [31:0]       fcs_word;
   logic [7:0]        fcs_byte;
   logic [LEN_W-1:0]  len_next;
   logic              start_ok;

   assign len_next = len_q + 1'b1;
   assign start_ok = tx_enable && fifo_not_empty && fifo_avail && !pause_busy;
   assign in_frame = (state_q != ST_IDLE) && (state_q != ST_GAP);
   assign fifo_rd  = (state_q == ST_DATA);
   assign fcs_word = ~crc_val;
   assign fcs_byte = fcs_word[8*step_q[1:0] +: 8];

   // ---------------- sub-blocks ----------------
   eth_txf_crc #(
      .POLY      (CRC_POLY),
      .LSB_FIRST (CRC_LSB_FIRST)
   ) u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (crc_clear),
      .advance (crc_adv),
      .din     (byte_d),
      .crc_o   (crc_val)
   );

   eth_txf_pause #(
      .QUANTA_W      (QUANTA_W),
      .QUANTUM_BYTES (QUANTUM_BYTES)
   ) u_pause (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (pause_req),
      .quanta   (pause_quanta),
      .in_frame (in_frame),
      .busy     (pause_busy)
   );

   // ---------------- sequencer ----------------
   always_comb begin
      state_d   = state_q;
      step_d    = step_q;
      len_d     = len_q;
      nofcs_d   = nofcs_q;
      byte_d    = 8'h00;
      en_d      = 1'b0;
      short_d   = 1'b0;
      crc_clear = 1'b0;
      crc_adv   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_ok) begin
               state_d = ST_PRE;
               step_d  = '0;
               nofcs_d = fcs_disable;
            end
         end
         ST_PRE: begin
            byte_d = PRE_BYTE;
            en_d   = 1'b1;
            if (step_q == STEP_W'(PREAMBLE_LEN - 1)) begin
               state_d = ST_SFD;
               step_d  = '0;
            end else begin
               step_d = step_q + 1'b1;
            end
         end
         ST_SFD: begin
            byte_d    = SFD_BYTE;
            en_d      = 1'b1;
            crc_clear = 1'b1;
            len_d     = '0;
            state_d   = ST_DATA;
         end
         ST_DATA: begin
            byte_d  = fifo_data;
            en_d    = 1'b1;
            crc_adv = 1'b1;
            len_d   = len_next;
            if (fifo_last) begin
               step_d = '0;
               if (nofcs_q) begin
                  state_d = ST_GAP;
                  short_d = (len_next < LEN_W'(MIN_FRAME));
               end else if (len_next < LEN_W'(PAD_TARGET)) begin
                  state_d = ST_PAD;
               end else begin
                  state_d = ST_FCS;
               end
            end
         end
         ST_PAD: begin
            byte_d  = 8'h00;
            en_d    = 1'b1;
            crc_adv = 1'b1;
            len_d   = len_next;
            if (len_next >= LEN_W'(PAD_TARGET)) begin
               state_d = ST_FCS;
               step_d  = '0;
            end
         end
         ST_FCS: begin
            byte_d = fcs_byte;
            en_d   = 1'b1;
            if (step_q == STEP_W'(FCS_LEN - 1)) begin
               state_d = ST_GAP;
               step_d  = '0;
            end else begin
               step_d = step_q + 1'b1;
            end
         end
         ST_GAP: begin
            if (step_q == STEP_W'(IFG_BYTES - 1)) begin
               state_d = ST_IDLE;
               step_d  = '0;
            end else begin
               step_d = step_q + 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         step_q  <= '0;
         len_q   <= '0;
         nofcs_q <= 1'b0;
      end else begin
         state_q <= state_d;
         step_q  <= step_d;
         len_q   <= len_d;
         nofcs_q <= nofcs_d;
      end
   end

   // ---------------- registered media outputs ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txd_o   <= 8'h00;
         tx_en_o <= 1'b0;
         gap_o   <= 1'b0;
         short_o <= 1'b0;
      end else begin
         txd_o   <= byte_d;
         tx_en_o <= en_d;
         gap_o   <= (state_q == ST_GAP);
         short_o <= short_d;
      end
   end

   // ---------------- assertions ----------------
   // R1: disabled and idle means no read and no start
   assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !tx_enable) |=> (state_q == ST_IDLE && !fifo_rd))
      else $error("activity while transmit disabled");

   // R2: a start needs all FIFO qualifiers
   assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PRE && $past(state_q) == ST_IDLE) |->
         $past(tx_enable && fifo_not_empty && fifo_avail))
      else $error("frame started without FIFO qualifiers");

   // R3: delimiter follows preamble on the wire
   assert_sfd_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SFD) |=> (tx_en_o && txd_o == SFD_BYTE))
      else $error("start delimiter missing");

   // R6: pad bytes are zero
   assert_pad_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PAD) |=> (tx_en_o && txd_o == 8'h00))
      else $error("nonzero pad byte");

   // R7: short pulse only accompanies a valid byte
   assert_short_with_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      short_o |-> tx_en_o)
      else $error("short pulse outside frame");

   // R9: pending hold-off keeps the sequencer idle
   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && pause_busy) |=> (state_q == ST_IDLE))
      else $error("frame started during hold-off");

   // R11: gap flag never overlaps valid data
   assert_gap_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      gap_o |-> !tx_en_o)
      else $error("data during interframe gap");

endmodule

// File: tb/eth_tx_framer_tb.sv
`timescale 1ns/1ps
module eth_tx_framer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_enable = 1'b0;
   logic        fcs_disable = 1'b0;
   logic        pause_req = 1'b0;
   logic [15:0] pause_quanta = '0;
   logic        fifo_not_empty;
   logic        fifo_avail = 1'b0;
   logic [7:0]  fifo_data;
   logic        fifo_last;
   logic        fifo_rd;
   logic [7:0]  txd_o;
   logic        tx_en_o;
   logic        gap_o;
   logic        short_o;

   always #2.5 clk = ~clk;

   eth_tx_framer u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .tx_enable      (tx_enable),
      .fcs_disable    (fcs_disable),
      .pause_req      (pause_req),
      .pause_quanta   (pause_quanta),
      .fifo_not_empty (fifo_not_empty),
      .fifo_avail     (fifo_avail),
      .fifo_data      (fifo_data),
      .fifo_last      (fifo_last),
      .fifo_rd        (fifo_rd),
      .txd_o          (txd_o),
      .tx_en_o        (tx_en_o),
      .gap_o          (gap_o),
      .short_o        (short_o)
   );

   // ---------------- FIFO model ----------------
   logic [7:0] mem [1024];
   logic       lastf [1024];
   int         head = 0;
   int         tail = 0;

   assign fifo_not_empty = (head < tail);
   assign fifo_data      = mem[head];
   assign fifo_last      = lastf[head];

   always @(posedge clk) begin
      if (fifo_rd) head <= head + 1;
   end

   task automatic load_frame(input int n, input int seed);
      for (int i = 0; i < n; i++) begin
         mem[tail + i]   = 8'((seed + i * 7) & 8'hFF);
         lastf[tail + i] = (i == n - 1);
      end
      tail = tail + n;
   endtask

   // ---------------- monitor ----------------
   logic [7:0] cap [4096];
   int cap_n = 0;
   int frames_n = 0;
   int fr_idx [32];
   int fr_len [32];
   int fr_start [32];
   int fr_end [32];
   int fr_short [32] = '{default: 0};
   int fr_short_pos [32] = '{default: -1};
   int gap_cnt = 0;
   int stray_short = 0;
   int cyc = 0;
   logic prev_en = 1'b0;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (tx_en_o) begin
         if (!prev_en) begin
            fr_start[frames_n] = cyc;
            fr_idx[frames_n]   = cap_n;
         end
         cap[cap_n] = txd_o;
         cap_n = cap_n + 1;
         if (short_o) begin
            fr_short[frames_n]     = fr_short[frames_n] + 1;
            fr_short_pos[frames_n] = cap_n - 1 - fr_idx[frames_n];
         end
      end else begin
         if (short_o) stray_short = stray_short + 1;
         if (prev_en) begin
            fr_end[frames_n] = cyc - 1;
            fr_len[frames_n] = cap_n - fr_idx[frames_n];
            frames_n = frames_n + 1;
         end
      end
      if (gap_o) gap_cnt = gap_cnt + 1;
      prev_en = tx_en_o;
   end

   // ---------------- checking helpers ----------------
   int tests = 0;
   int fails = 0;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      tests = tests + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic wait_frames(input int target, input int limit);
      for (int i = 0; i < limit && frames_n < target; i++) @(negedge clk);
   endtask

   function automatic logic [31:0] ref_crc(input logic [7:0] b [128], input int n);
      logic [31:0] c;
      c = 32'hFFFF_FFFF;
      for (int k = 0; k < n; k++) begin
         c = c ^ {24'h0, b[k]};
         for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
      return ~c;
   endfunction

   // compare captured frame k against the frame built from the requirements
   task automatic check_frame(input int k, input int n, input int seed, input bit fcs_on);
      logic [7:0] body [128];
      int blen, elen, bad_pre, bad_body, bad_fcs, base;
      logic [31:0] f;
      blen = n;
      for (int i = 0; i < n; i++) body[i] = 8'((seed + i * 7) & 8'hFF);
      if (fcs_on) begin
         for (int i = n; i < 60; i++) body[i] = 8'h00;
         if (blen < 60) blen = 60;
      end
      elen = 8 + blen + (fcs_on ? 4 : 0);
      chk(fr_len[k] == elen, "R4 frame length", fr_len[k], elen);
      if (fr_len[k] != elen) return;
      base = fr_idx[k];
      bad_pre = 0; bad_body = 0; bad_fcs = 0;
      for (int i = 0; i < 7; i++) if (cap[base + i] != 8'h55) bad_pre++;
      if (cap[base + 7] != 8'hD5) bad_pre++;
      chk(bad_pre == 0, "R3 preamble/SFD", bad_pre, 0);
      for (int i = 0; i < blen; i++) if (cap[base + 8 + i] != body[i]) bad_body++;
      chk(bad_body == 0, fcs_on ? "R4/R6 data and pad" : "R7 unchanged data", bad_body, 0);
      if (fcs_on) begin
         f = ref_crc(body, blen);
         for (int i = 0; i < 4; i++)
            if (cap[base + 8 + blen + i] != f[8*i +: 8]) bad_fcs++;
         chk(bad_fcs == 0, "R5 FCS", bad_fcs, 0);
      end
   endtask

   task automatic pulse_pause(input int q);
      @(negedge clk);
      pause_quanta = 16'(q);
      pause_req    = 1'b1;
      @(negedge clk);
      pause_req    = 1'b0;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      chk(!tx_en_o && !short_o && !gap_o && !fifo_rd, "R12 reset outputs",
          {28'h0, tx_en_o, short_o, gap_o, fifo_rd}, 0);
   endtask

   task automatic t_disabled;
      int k0, h0;
      k0 = frames_n; h0 = head;
      tx_enable = 1'b0; fifo_avail = 1'b1; fcs_disable = 1'b0;
      load_frame(40, 3);
      repeat (40) @(negedge clk);
      chk(frames_n == k0, "R1 no frame while disabled", frames_n, k0);
      chk(head == h0, "R1 no FIFO read while disabled", head, h0);
      tx_enable = 1'b1;
      wait_frames(k0 + 1, 300);
      chk(frames_n == k0 + 1, "R1 frame after enable", frames_n, k0 + 1);
      check_frame(k0, 40, 3, 1'b1);
   endtask

   task automatic t_avail_gate;
      int k0, h0;
      repeat (20) @(negedge clk);
      fifo_avail = 1'b0;
      k0 = frames_n; h0 = head;
      load_frame(64, 11);
      repeat (40) @(negedge clk);
      chk(frames_n == k0 && !tx_en_o, "R2 no start without avail", frames_n, k0);
      chk(head == h0, "R2 no read without avail", head, h0);
      fifo_avail = 1'b1;
      wait_frames(k0 + 1, 300);
      check_frame(k0, 64, 11, 1'b1);
      chk(fr_short[k0] == 0, "R7 no short pulse with FCS on", fr_short[k0], 0);
   endtask

   task automatic t_pad;
      int k0;
      repeat (20) @(negedge clk);
      k0 = frames_n;
      load_frame(20, 99);
      wait_frames(k0 + 1, 300);
      check_frame(k0, 20, 99, 1'b1);
   endtask

   task automatic t_nofcs;
      int k0;
      repeat (20) @(negedge clk);
      fifo_avail = 1'b0;
      fcs_disable = 1'b1;
      k0 = frames_n;
      load_frame(30, 5);
      load_frame(70, 8);
      fifo_avail = 1'b1;
      wait_frames(k0 + 2, 600);
      check_frame(k0, 30, 5, 1'b0);
      chk(fr_short[k0] == 1, "R7 short pulse count", fr_short[k0], 1);
      chk(fr_short_pos[k0] == 37, "R7 short pulse on last byte", fr_short_pos[k0], 37);
      check_frame(k0 + 1, 70, 8, 1'b0);
      chk(fr_short[k0 + 1] == 0, "R7 no pulse for long frame", fr_short[k0 + 1], 0);
      chk(stray_short == 0, "R7 no stray pulse", stray_short, 0);
      repeat (20) @(negedge clk);
      fcs_disable = 1'b0;
   endtask

   task automatic t_back2back;
      int k0, g0, idle;
      repeat (20) @(negedge clk);
      fifo_avail = 1'b0;
      k0 = frames_n; g0 = gap_cnt;
      load_frame(60, 21);
      load_frame(60, 77);
      fifo_avail = 1'b1;
      wait_frames(k0 + 2, 600);
      check_frame(k0, 60, 21, 1'b1);
      check_frame(k0 + 1, 60, 77, 1'b1);
      idle = fr_start[k0 + 1] - fr_end[k0] - 1;
      chk(idle >= 12, "R11 interframe idle", idle, 12);
      repeat (20) @(negedge clk);
      chk(gap_cnt - g0 == 24, "R11 gap flag cycles", gap_cnt - g0, 24);
   endtask

   task automatic t_pause;
      int k0, d;
      repeat (20) @(negedge clk);
      k0 = frames_n;
      load_frame(64, 40);
      for (int i = 0; i < 200 && !tx_en_o; i++) @(negedge clk);
      repeat (10) @(negedge clk);
      pulse_pause(2);
      load_frame(10, 41);
      wait_frames(k0 + 2, 2000);
      chk(frames_n == k0 + 2, "R9 both frames sent", frames_n, k0 + 2);
      chk(fr_len[k0] == 76, "R8 frame not truncated", fr_len[k0], 76);
      check_frame(k0, 64, 40, 1'b1);
      d = fr_start[k0 + 1] - fr_end[k0];
      chk(d >= 128, "R9 hold-off length min", d, 128);
      chk(d <= 150, "R9 hold-off length max", d, 150);
   endtask

   task automatic t_cancel;
      int k0, c0, d;
      repeat (20) @(negedge clk);
      fifo_avail = 1'b0;
      pulse_pause(20);
      k0 = frames_n;
      load_frame(30, 60);
      fifo_avail = 1'b1;
      repeat (100) @(negedge clk);
      chk(frames_n == k0 && !tx_en_o, "R9 held during pause", frames_n, k0);
      pulse_pause(0);
      c0 = cyc;
      wait_frames(k0 + 1, 200);
      chk(frames_n == k0 + 1, "R10 frame after cancel", frames_n, k0 + 1);
      d = fr_start[k0] - c0;
      chk(d <= 20, "R10 prompt start after cancel", d, 20);
      check_frame(k0, 30, 60, 1'b1);
   endtask

   // ---------------- run ----------------
   bit done = 1'b0;

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_disabled();
      t_avail_gate();
      t_pad();
      t_nofcs();
      t_back2back();
      t_pause();
      t_cancel();
      repeat (10) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests = tests + 1;
         fails = fails + 1;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule